// File: doc/BRIEF.md
# Two-Speed Clock Start-Up Controller

This block picks the system clock whenever the chip comes out of power-up or out of sleep. A crystal oscillator needs time to settle, so the core keeps running from the internal oscillator in the meantime. A counter in the crystal's own clock domain counts 1024 of its rising edges. Once that count is seen in the internal domain, the block sets a ready flag and moves the system clock to the crystal. The move goes through a glitch-free gate pair, so no short pulse reaches the core.

Sources that need no settling (an external clock input or an RC oscillator) are used at once, with no count. A software clock-select field other than zero keeps the core on the internal oscillator. If sleep is entered before the count completes, the pending move to the crystal is dropped and the ready flag stays clear. Each wake-up starts a fresh count. While the chip is asleep the system clock is held low.

Top module: `twospeed_clk_start`

## Requirements
- R1: After reset, `osc_ready` and `ext_active` are 0. Until the first start event, `sys_clk` follows `clk_int`.
- R2: With a crystal mode (`osc_mode` 0, 1 or 2), `twospeed_en`=1 and `clk_sel`=00, after a start event `osc_ready` and `ext_active` stay 0 until at least 1024 rising edges of `clk_ext` have occurred. During that time `sys_clk` follows `clk_int`.
- R3: Once the count is complete, `osc_ready` goes to 1, `ext_active` goes to 1 and `sys_clk` follows `clk_ext`. This happens no later than 16 `clk_int` cycles after the 1032nd `clk_ext` edge since the start event. In a crystal mode, `ext_active` is never 1 while `osc_ready` is 0.
- R4: A `sleep_req` pulse during the count aborts it. `osc_ready` stays 0 and `ext_active` stays 0 for the rest of that awake period and through the sleep that follows.
- R5: While asleep, `sys_clk` is held low and `osc_ready` keeps the value it had on entry. `ext_active` returns to 0 within 10 `clk_int` cycles of the `sleep_req` pulse.
- R6: The first start event is a `pwrt_done` pulse after reset. Every later start event is a `wake_req` pulse while asleep, and it is accepted once `ext_active` is 0. Each start event clears `osc_ready` in crystal modes and needs a complete new count of 1024 edges.
- R7: For `osc_mode` 3 to 7 (external clock or RC), no count is made. `osc_ready` is set by the start event itself, and `sys_clk` follows `clk_ext` with `ext_active`=1 within 16 `clk_int` cycles.
- R8: With a crystal mode and `twospeed_en`=0, `sys_clk` is held low for the whole count and then follows `clk_ext`.
- R9: When `clk_sel` is not 00, `sys_clk` stays on `clk_int` and `ext_active` is 0, while `osc_ready` still reports that the count has finished. Setting `clk_sel` back to 00 after the count moves `sys_clk` to `clk_ext`.
- R10: Changes of clock source are glitch-free. No high or low phase of `sys_clk` is shorter than the shorter half-period of the two sources, and the two clock gates are never open at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal oscillator clock; the control logic runs on this clock |
| clk_ext | input | 1 | External oscillator or clock input |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrt_done | input | 1 | One-cycle pulse when the power-up delay ends (first start event) |
| sleep_req | input | 1 | One-cycle pulse on sleep entry |
| wake_req | input | 1 | One-cycle pulse on wake-up from sleep |
| twospeed_en | input | 1 | Configuration bit that enables running from the internal clock during the count |
| clk_sel | input | 2 | Clock-select field; 00 lets the oscillator mode decide, any other value forces the internal clock |
| osc_mode | input | 3 | 0 low-power crystal, 1 standard crystal, 2 high-speed crystal, 3 external clock, 4 to 7 RC |
| sys_clk | output | 1 | System clock delivered to the core |
| ext_active | output | 1 | 1 while the external source drives `sys_clk` |
| osc_ready | output | 1 | Oscillator-ready status; set when the warm-up count completes |

## Verification
The bench aims at the edges of the 1024-edge window. A counter that ends early raises `osc_ready` before the bench has counted 1024 external edges, and a done flag that never crosses into the internal domain leaves the ready deadline unmet. Sleep is entered both halfway through a count and after a completed one. An abort that is not honoured switches to the crystal while asleep or lets the ready flag rise, and a wake that does not restart the count shows ready at once. The non-crystal modes, the held-low clock with the enable bit cleared, and a forced internal select (including its release back to 00) are run from sleep, and the bench counts `sys_clk` edges against each source. Every `sys_clk` phase is timed, so a gate opened on the wrong edge shows up as a runt.

// File: rtl/twospeed_clk_start.sv
module twospeed_clk_start #(
  parameter int WARM_EDGES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_int,
  input  logic       clk_ext,
  input  logic       rst_n,
  input  logic       pwrt_done,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       twospeed_en,
  input  logic [1:0] clk_sel,
  input  logic [2:0] osc_mode,
  output logic       sys_clk,
  output logic       ext_active,
  output logic       osc_ready
);

  localparam int CW = $clog2(WARM_EDGES + 1);
  localparam int SL = SYNC_STAGES - 1;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_CLR   = 3'd1,
    ST_WARM  = 3'd2,
    ST_EXT   = 3'd3,
    ST_SLEEP = 3'd4
  } st_t;

  st_t st;

  logic [SL:0]   done_i, en_ext_i;
  logic [SL:0]   run_x, sel_x, en_int_x;
  logic [CW-1:0] cnt;
  logic          done_x;
  logic          en_int, en_ext;

  wire is_xtal   = osc_mode < 3'd3;
  wire done_s    = done_i[SL];
  wire ext_on_s  = en_ext_i[SL];
  wire start_evt = (st == ST_OFF && pwrt_done) ||
                   (st == ST_SLEEP && wake_req && !ext_on_s);
  wire sel_ext   = (st == ST_EXT) && (clk_sel == 2'b00);
  wire warming   = (st == ST_CLR) || (st == ST_WARM);
  wire int_allow = (st != ST_SLEEP) && !(warming && is_xtal && !twospeed_en);

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      osc_ready <= 1'b0;
    end else if (start_evt) begin
      osc_ready <= !is_xtal;
      st        <= is_xtal ? ST_CLR : ST_EXT;
    end else begin
      case (st)
        ST_CLR:  if (sleep_req) st <= ST_SLEEP;
                 else if (!done_s) st <= ST_WARM;
        ST_WARM: if (sleep_req) st <= ST_SLEEP;
                 else if (done_s) begin
                   st        <= ST_EXT;
                   osc_ready <= 1'b1;
                 end
        ST_EXT:  if (sleep_req) st <= ST_SLEEP;
        default: st <= st;
      endcase
    end
  end

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      done_i   <= '0;
      en_ext_i <= '0;
    end else begin
      done_i   <= {done_i[SL-1:0], done_x};
      en_ext_i <= {en_ext_i[SL-1:0], en_ext};
    end
  end

  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) begin
      run_x    <= '0;
      sel_x    <= '0;
      en_int_x <= '0;
    end else begin
      run_x    <= {run_x[SL-1:0], st == ST_WARM};
      sel_x    <= {sel_x[SL-1:0], sel_ext};
      en_int_x <= {en_int_x[SL-1:0], en_int};
    end
  end

  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_x <= 1'b0;
    end else if (!run_x[SL]) begin
      cnt    <= '0;
      done_x <= 1'b0;
    end else if (!done_x) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(WARM_EDGES - 1)) done_x <= 1'b1;
    end
  end

  always_ff @(negedge clk_int or negedge rst_n) begin
    if (!rst_n) en_int <= 1'b0;
    else        en_int <= !sel_ext && int_allow && !ext_on_s;
  end

  always_ff @(negedge clk_ext or negedge rst_n) begin
    if (!rst_n) en_ext <= 1'b0;
    else        en_ext <= sel_x[SL] && !en_int_x[SL];
  end

  assign sys_clk    = (clk_int & en_int) | (clk_ext & en_ext);
  assign ext_active = ext_on_s;

endmodule

// File: rtl/twospeed_clk_start_chk.sv
module twospeed_clk_start_chk (
  input logic       clk_int,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       en_int,
  input logic       en_ext,
  input logic       sleep_req,
  input logic       wake_req,
  input logic       ext_active,
  input logic       osc_ready,
  input logic [2:0] osc_mode
);

  assert_no_overlap_R10: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(en_int && en_ext));

  assert_abort_R4: assert property (@(posedge clk_int) disable iff (!rst_n)
    (st == 3'd2 && sleep_req) |=> (st == 3'd4 && !osc_ready));

  assert_sleep_gate_R5: assert property (@(posedge clk_int) disable iff (!rst_n)
    (st == 3'd4) |-> !en_int);

  assert_ready_hold_R5: assert property (@(posedge clk_int) disable iff (!rst_n)
    (st == 3'd4 && $past(st) == 3'd4) |-> $stable(osc_ready));

  assert_ext_needs_ready_R3: assert property (@(posedge clk_int) disable iff (!rst_n)
    (ext_active && osc_mode < 3'd3) |-> osc_ready);

  assert_wake_clear_R6: assert property (@(posedge clk_int) disable iff (!rst_n)
    (st == 3'd4 && wake_req && !ext_active && osc_mode < 3'd3) |=> !osc_ready);

endmodule

bind twospeed_clk_start twospeed_clk_start_chk u_chk (
  .clk_int    (clk_int),
  .rst_n      (rst_n),
  .st         (st),
  .en_int     (en_int),
  .en_ext     (en_ext),
  .sleep_req  (sleep_req),
  .wake_req   (wake_req),
  .ext_active (ext_active),
  .osc_ready  (osc_ready),
  .osc_mode   (osc_mode)
);

// File: tb/twospeed_clk_start_bench.sv
module twospeed_clk_start_bench;
  logic       clk_int = 1'b0, clk_ext = 1'b0, rst_n = 1'b0;
  logic       pwrt_done = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
  logic       twospeed_en = 1'b1;
  logic [1:0] clk_sel = 2'b00;
  logic [2:0] osc_mode = 3'd1;
  logic       sys_clk, ext_active, osc_ready;

  always #10 clk_int = ~clk_int;
  always #7  clk_ext = ~clk_ext;

  twospeed_clk_start u_twospeed_clk_start (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n), .pwrt_done(pwrt_done),
    .sleep_req(sleep_req), .wake_req(wake_req), .twospeed_en(twospeed_en),
    .clk_sel(clk_sel), .osc_mode(osc_mode), .sys_clk(sys_clk),
    .ext_active(ext_active), .osc_ready(osc_ready));

  int total = 0, bad = 0;
  localparam int M_OFF = 0, M_WARM = 1, M_DIRECT = 2, M_SLEEP = 3;
  int m_st = M_OFF, ext_cnt = 0, late = 0, sleep_age = 0;
  bit m_ready = 1'b0, m_hold = 1'b0;
  int sys_e = 0, ext_e = 0;
  time last_t = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk_ext) if (m_st == M_WARM) ext_cnt++;
  always @(posedge clk_ext) ext_e++;
  always @(posedge sys_clk) sys_e++;

  always @(sys_clk) if (rst_n) begin
    if (last_t != 0)
      check(($time - last_t) >= 6, "R10", "sys_clk phase width", int'($time - last_t), 6);
    last_t = $time;
  end

  always @(posedge clk_int) begin
    #4;
    if (rst_n) begin
      case (m_st)
        M_WARM: begin
          if (ext_cnt < 1024) begin
            check(osc_ready == 1'b0, "R2", "ready during count", osc_ready, 0);
            check(ext_active == 1'b0, "R2", "ext_active during count", ext_active, 0);
            if (m_hold && ext_cnt >= 8)
              check(sys_clk == 1'b0, "R8", "sys_clk held low in count", sys_clk, 0);
          end
          if (ext_cnt >= 1032) late++;
          if (late >= 16) begin
            m_ready = 1'b1;
            check(osc_ready == 1'b1, "R3", "ready after count", osc_ready, 1);
            check(ext_active == (clk_sel == 2'b00), "R3", "ext_active after count (R9 sel)",
                  ext_active, int'(clk_sel == 2'b00));
          end
        end
        M_DIRECT: begin
          late++;
          if (late >= 16) begin
            check(osc_ready == 1'b1, "R7", "ready direct mode", osc_ready, 1);
            check(ext_active == 1'b1, "R7", "ext_active direct mode", ext_active, 1);
          end
        end
        M_SLEEP: begin
          sleep_age++;
          check(osc_ready == m_ready, "R5", "ready kept in sleep", osc_ready, int'(m_ready));
          if (sleep_age >= 10) begin
            check(sys_clk == 1'b0, "R5", "sys_clk low in sleep", sys_clk, 0);
            check(ext_active == 1'b0, "R5", "ext_active in sleep", ext_active, 0);
          end
        end
        default: ;
      endcase
    end
  end

  task automatic follow(input int src, input string req);
    int s, e;
    @(negedge clk_int);
    sys_e = 0;
    ext_e = 0;
    repeat (40) @(negedge clk_int);
    s = sys_e;
    e = ext_e;
    case (src)
      0: check(s >= 39 && s <= 41, req, "sys_clk edges vs internal", s, 40);
      1: check(s >= e - 1 && s <= e + 1, req, "sys_clk edges vs external", s, e);
      default: check(s == 0, req, "sys_clk edges while gated", s, 0);
    endcase
  endtask

  task automatic start(input bit use_wake);
    @(negedge clk_int);
    if (use_wake) wake_req = 1'b1; else pwrt_done = 1'b1;
    ext_cnt = 0;
    late    = 0;
    if (osc_mode < 3'd3) begin
      m_st    = M_WARM;
      m_ready = 1'b0;
      m_hold  = !twospeed_en;
    end else begin
      m_st    = M_DIRECT;
      m_ready = 1'b1;
      m_hold  = 1'b0;
    end
    @(negedge clk_int);
    wake_req  = 1'b0;
    pwrt_done = 1'b0;
  endtask

  task automatic go_sleep();
    @(negedge clk_int);
    sleep_req = 1'b1;
    m_st      = M_SLEEP;
    sleep_age = 0;
    @(negedge clk_int);
    sleep_req = 1'b0;
  endtask

  task automatic wait_done();
    while (!(ext_cnt >= 1032 && late >= 20)) @(negedge clk_int);
  endtask

  initial begin
    repeat (5) @(negedge clk_int);
    check(osc_ready == 1'b0, "R1", "ready in reset", osc_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_int);
    check(osc_ready == 1'b0, "R1", "ready after reset", osc_ready, 0);
    check(ext_active == 1'b0, "R1", "ext_active after reset", ext_active, 0);
    follow(0, "R1");

    start(1'b0);
    repeat (100) @(negedge clk_int);
    follow(0, "R2");
    wait_done();
    follow(1, "R3");
    check(osc_ready == 1'b1, "R3", "ready after first count", osc_ready, 1);

    go_sleep();
    repeat (30) @(negedge clk_int);
    follow(2, "R5");
    check(osc_ready == 1'b1, "R5", "ready kept through sleep", osc_ready, 1);

    start(1'b1);
    repeat (3) @(negedge clk_int);
    check(osc_ready == 1'b0, "R6", "ready cleared by wake", osc_ready, 0);
    repeat (300) @(negedge clk_int);
    go_sleep();
    repeat (40) @(negedge clk_int);
    check(osc_ready == 1'b0, "R4", "ready after abort", osc_ready, 0);
    check(ext_active == 1'b0, "R4", "ext_active after abort", ext_active, 0);
    follow(2, "R4");

    start(1'b1);
    repeat (200) @(negedge clk_int);
    follow(0, "R6");
    wait_done();
    follow(1, "R6");

    go_sleep();
    osc_mode = 3'd3;
    repeat (40) @(negedge clk_int);
    start(1'b1);
    repeat (20) @(negedge clk_int);
    check(osc_ready == 1'b1, "R7", "ready external clock mode", osc_ready, 1);
    follow(1, "R7");

    go_sleep();
    osc_mode = 3'd6;
    repeat (40) @(negedge clk_int);
    start(1'b1);
    repeat (20) @(negedge clk_int);
    follow(1, "R7");

    go_sleep();
    osc_mode    = 3'd2;
    twospeed_en = 1'b0;
    repeat (40) @(negedge clk_int);
    start(1'b1);
    repeat (100) @(negedge clk_int);
    follow(2, "R8");
    wait_done();
    follow(1, "R8");

    go_sleep();
    osc_mode    = 3'd0;
    twospeed_en = 1'b1;
    clk_sel     = 2'b01;
    repeat (40) @(negedge clk_int);
    start(1'b1);
    wait_done();
    follow(0, "R9");
    check(ext_active == 1'b0, "R9", "ext_active with forced internal", ext_active, 0);
    check(osc_ready == 1'b1, "R9", "ready with forced internal", osc_ready, 1);
    m_st    = M_OFF;
    clk_sel = 2'b00;
    repeat (30) @(negedge clk_int);
    follow(1, "R9");
    check(ext_active == 1'b1, "R9", "ext_active after select release", ext_active, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_int);
    total++;
    bad++;
    $display("FAIL watchdog all requirements actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule